// File: doc/BRIEF.md
# Asynchronous DRAM Wake-Up and Refresh Sequencer

This block is the refresh master of a controller for fast-page or extended-data-out asynchronous DRAM. It leaves every strobe inactive after reset for a programmed number of clock cycles. It then runs a back-to-back burst of CAS-before-RAS refresh cycles to wake the memory and only then raises `ready`. After that it issues one CAS-before-RAS refresh each time a fixed number of cycles has passed since the previous refresh ended. Because these refresh cycles use the memory's internal row counter, the block drives no row address. It holds WE# and OE# high throughout.

An access arbiter requests the memory with `acc_req`, owns it while `acc_gnt` is high, and hands it back with a one-cycle `acc_done`. A refresh that has come due wins over a new request, but it never cuts short an access that is already granted. An age counter tracks the cycles since the last completed refresh. If an access holds the memory past the configured limit, the refresh period counts as broken: `ready` drops, and once the access ends the whole wake-up burst runs again before `ready` returns.

Top module: `dram_wake_refresh`

## Requirements
- R1: While `rst_n` is low, `ras_n`, `cas_n`, `we_n` and `oe_n` are high and `ready`, `acc_gnt` and `ref_busy` are low.
- R2: After `rst_n` rises, the first strobe falls no earlier than PAUSE_CYC and no later than PAUSE_CYC+2 clock cycles later (the extra two cycles are the synchronous reset release).
- R3: The pause is followed by exactly WAKE_CNT refresh cycles, with RAS# falling edges spaced CAS_LEAD+RAS_W+PRE_W cycles apart. `ready` rises only after the last of them, and `acc_req` gets no grant before that.
- R4: Every refresh is CAS-before-RAS: RAS# is low only while CAS# is low, and `we_n` and `oe_n` are high at all times.
- R5: In each refresh cycle CAS# is low for CAS_LEAD cycles before RAS# falls, and RAS# (with CAS#) then stays low for exactly RAS_W cycles.
- R6: Once ready and with no access, consecutive RAS# falling edges are spaced REF_INTERVAL+CAS_LEAD+RAS_W+PRE_W+1 cycles apart, and `ready` stays high through these periodic refreshes.
- R7: A request seen while idle with no refresh due is granted in the next cycle. The grant stays high until `acc_done` is sampled and falls in the cycle after that.
- R8: A request made while a refresh is due or running gets no grant until that refresh has ended. While the grant is high, no strobe falls even if a refresh comes due, and that refresh starts in the second cycle after `acc_done`.
- R9: If no refresh completes within REF_MAX cycles, `ready` falls. When the access ends, a full WAKE_CNT-cycle burst runs with `ready` low, and `ready` rises again afterwards. Accesses that end sooner leave `ready` high.
- R10: `ref_busy` is high from the first cycle of CAS# low through the last precharge cycle of a refresh, including the cycle in which RAS# falls, and low while a grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_req | input | 1 | Access request from the arbiter |
| acc_done | input | 1 | One-cycle pulse: the granted access has finished |
| acc_gnt | output | 1 | Memory handed to the access path |
| ready | output | 1 | Wake-up complete and refresh period intact |
| ref_busy | output | 1 | A refresh cycle is on the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| oe_n | output | 1 | Output enable, held high |

## Verification
The refresh path is first run with a request already held high through reset and wake-up, to show that the request is ignored until the burst is complete. It is then run with the bus idle, which separates the periodic spacing from the back-to-back burst spacing. A table of access lengths follows, each access started just after a refresh ends. Short holds show that no refresh and no lapse occur. Middle holds cross the refresh deadline and show that the refresh is deferred to just after the access. Long holds cross the lapse limit and show that `ready` drops and the eight-cycle burst repeats. Directed cases raise a request at the moment a refresh begins and apply reset in mid-operation.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_CAS,
    ST_RAS,
    ST_PRE,
    ST_IDLE,
    ST_ACC
  } dwr_state_e;
endpackage

// File: rtl/dwr_rst_sync.sv
module dwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/dwr_age_watch.sv
module dwr_age_watch #(
  parameter int REF_INTERVAL = 3000,
  parameter int REF_MAX      = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic due,
  output logic lapse
);
  localparam int AW = $clog2(REF_MAX + 1);
  localparam logic [AW-1:0] AGE_DUE = AW'(REF_INTERVAL);
  localparam logic [AW-1:0] AGE_MAX = AW'(REF_MAX);

  logic [AW-1:0] age_q, age_d;

  always_comb begin
    if (clr)                   age_d = '0;
    else if (age_q == AGE_MAX) age_d = age_q;
    else                       age_d = age_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  assign due   = (age_q >= AGE_DUE);
  assign lapse = (age_q == AGE_MAX);
endmodule

// File: rtl/dwr_ctl.sv
module dwr_ctl
  import dwr_pkg::*;
#(
  parameter int PAUSE_CYC = 20000,
  parameter int WAKE_CNT  = 8,
  parameter int CAS_LEAD  = 2,
  parameter int RAS_W     = 10,
  parameter int PRE_W     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic acc_done,
  input  logic due,
  input  logic lapse,
  output logic ras_n,
  output logic cas_n,
  output logic ref_busy,
  output logic acc_gnt,
  output logic ready,
  output logic ref_done,
  output logic pausing
);
  localparam int M1   = (CAS_LEAD > RAS_W) ? CAS_LEAD : RAS_W;
  localparam int M2   = (M1 > PRE_W) ? M1 : PRE_W;
  localparam int MAXD = (M2 > PAUSE_CYC) ? M2 : PAUSE_CYC;
  localparam int TW   = $clog2(MAXD + 1);
  localparam int KW   = $clog2(WAKE_CNT + 1);
  localparam logic [TW-1:0] T_PAUSE = TW'(PAUSE_CYC - 1);
  localparam logic [TW-1:0] T_CAS   = TW'(CAS_LEAD - 1);
  localparam logic [TW-1:0] T_RAS   = TW'(RAS_W - 1);
  localparam logic [TW-1:0] T_PRE   = TW'(PRE_W - 1);
  localparam logic [KW-1:0] K_WAKE  = KW'(WAKE_CNT);

  dwr_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [KW-1:0] wk_q, wk_d;
  logic          ras_q, cas_q;
  logic          tmr_end;

  assign tmr_end = (tmr_q == '0);

  always_comb begin
    state_d  = state_q;
    tmr_d    = tmr_end ? tmr_q : tmr_q - 1'b1;
    wk_d     = wk_q;
    ref_done = 1'b0;
    case (state_q)
      ST_PAUSE: if (tmr_end) begin
        state_d = ST_CAS;
        tmr_d   = T_CAS;
      end
      ST_CAS: if (tmr_end) begin
        state_d = ST_RAS;
        tmr_d   = T_RAS;
      end
      ST_RAS: if (tmr_end) begin
        state_d = ST_PRE;
        tmr_d   = T_PRE;
      end
      ST_PRE: if (tmr_end) begin
        ref_done = 1'b1;
        wk_d     = (wk_q != '0) ? wk_q - 1'b1 : wk_q;
        if (wk_q > KW'(1)) begin
          state_d = ST_CAS;
          tmr_d   = T_CAS;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (lapse) begin
          state_d = ST_CAS;
          tmr_d   = T_CAS;
          wk_d    = K_WAKE;
        end else if (due) begin
          state_d = ST_CAS;
          tmr_d   = T_CAS;
        end else if (acc_req) begin
          state_d = ST_ACC;
        end
      end
      ST_ACC: if (acc_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PAUSE;
      tmr_q   <= T_PAUSE;
      wk_q    <= K_WAKE;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      wk_q    <= wk_d;
      ras_q   <= (state_d != ST_RAS);
      cas_q   <= !((state_d == ST_CAS) || (state_d == ST_RAS));
    end
  end

  assign ras_n    = ras_q;
  assign cas_n    = cas_q;
  assign ref_busy = (state_q == ST_CAS) || (state_q == ST_RAS) || (state_q == ST_PRE);
  assign acc_gnt  = (state_q == ST_ACC);
  assign ready    = (wk_q == '0) && !lapse;
  assign pausing  = (state_q == ST_PAUSE);
endmodule

// File: rtl/dram_wake_refresh.sv
module dram_wake_refresh #(
  parameter int PAUSE_CYC    = 20000,
  parameter int WAKE_CNT     = 8,
  parameter int CAS_LEAD     = 2,
  parameter int RAS_W        = 10,
  parameter int PRE_W        = 8,
  parameter int REF_INTERVAL = 3000,
  parameter int REF_MAX      = 3120,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req,
  input  logic acc_done,
  output logic acc_gnt,
  output logic ready,
  output logic ref_busy,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic oe_n
);
  logic srst_n;
  logic due, lapse, ref_done, pausing;

  dwr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dwr_age_watch #(
    .REF_INTERVAL (REF_INTERVAL),
    .REF_MAX      (REF_MAX)
  ) u_age (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (ref_done | pausing),
    .due   (due),
    .lapse (lapse)
  );

  dwr_ctl #(
    .PAUSE_CYC (PAUSE_CYC),
    .WAKE_CNT  (WAKE_CNT),
    .CAS_LEAD  (CAS_LEAD),
    .RAS_W     (RAS_W),
    .PRE_W     (PRE_W)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (srst_n),
    .acc_req  (acc_req),
    .acc_done (acc_done),
    .due      (due),
    .lapse    (lapse),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .ref_busy (ref_busy),
    .acc_gnt  (acc_gnt),
    .ready    (ready),
    .ref_done (ref_done),
    .pausing  (pausing)
  );

  assign we_n = 1'b1;
  assign oe_n = 1'b1;
endmodule

// File: rtl/dwr_chk.sv
module dwr_chk #(
  parameter int CAS_LEAD = 2,
  parameter int RAS_W    = 10
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic ref_busy,
  input logic acc_gnt,
  input logic acc_done
);
  localparam int CW = $clog2(RAS_W + CAS_LEAD + 2) + 1;
  logic [CW-1:0] ras_low_q, cas_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_low_q <= '0;
      cas_low_q <= '0;
    end else begin
      ras_low_q <= ras_n ? '0 : ras_low_q + 1'b1;
      cas_low_q <= cas_n ? '0 : cas_low_q + 1'b1;
    end
  end

  // R4: row strobe only low inside a column-strobe-low window
  p_cbr_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  // R5: column strobe leads the row strobe by CAS_LEAD cycles
  p_cas_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (cas_low_q == CW'(CAS_LEAD)));

  // R5: row strobe low width
  p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_low_q == CW'(RAS_W)));

  // R10: any strobe activity is flagged as busy
  p_busy_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> ref_busy);

  // R8: strobes stay quiet while the access path owns the memory
  p_gnt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> (ras_n && cas_n && !ref_busy));

  // R7: grant held until done
  p_gnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_gnt && !acc_done) |=> acc_gnt);

  // R7: grant released after done
  p_gnt_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_gnt && acc_done) |=> !acc_gnt);
endmodule

bind dram_wake_refresh dwr_chk #(
  .CAS_LEAD (CAS_LEAD),
  .RAS_W    (RAS_W)
) u_dwr_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .ref_busy (ref_busy),
  .acc_gnt  (acc_gnt),
  .acc_done (acc_done)
);

// File: tb/test_dram_wake_refresh.sv
`timescale 1ns/1ps
module test_dram_wake_refresh;
  localparam int PAUSE  = 50;
  localparam int WAKE   = 8;
  localparam int LEAD   = 2;
  localparam int RASW   = 4;
  localparam int PREW   = 3;
  localparam int IVL    = 40;
  localparam int LIM    = 100;
  localparam int BURST_GAP = LEAD + RASW + PREW;
  localparam int IDLE_GAP  = IVL + LEAD + RASW + PREW + 1;

  // {hold cycles, lapse expected, refresh due at end}
  localparam int TBL [7][3] = '{
    '{3,   0, 0},
    '{30,  0, 0},
    '{45,  0, 1},
    '{80,  0, 1},
    '{130, 1, 1},
    '{12,  0, 0},
    '{220, 1, 1}
  };

  logic clk, rst_n, acc_req, acc_done;
  logic acc_gnt, ready, ref_busy, ras_n, cas_n, we_n, oe_n;

  int checks, bad, mon_checks, mon_bad, wd_cyc;

  dram_wake_refresh #(
    .PAUSE_CYC (PAUSE), .WAKE_CNT (WAKE), .CAS_LEAD (LEAD), .RAS_W (RASW),
    .PRE_W (PREW), .REF_INTERVAL (IVL), .REF_MAX (LIM), .SYNC_STAGES (2)
  ) i_dram_wake_refresh (
    .clk (clk), .rst_n (rst_n), .acc_req (acc_req), .acc_done (acc_done),
    .acc_gnt (acc_gnt), .ready (ready), .ref_busy (ref_busy),
    .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .oe_n (oe_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // strobe monitor: lead, width, busy and quiet-grant rules
  logic m_prev;
  int   m_cas_run, m_ras_run;
  always @(negedge clk) begin
    if (!rst_n) begin
      m_prev = 1'b1; m_cas_run = 0; m_ras_run = 0;
    end else begin
      if (m_prev && !ras_n) begin
        mon_checks += 3;
        if (m_cas_run != LEAD) begin mon_bad++; $display("FAIL R5 lead actual=%0d expected=%0d", m_cas_run, LEAD); end
        if (!ref_busy) begin mon_bad++; $display("FAIL R10 busy actual=%0d expected=1", ref_busy); end
        if (!(we_n && oe_n)) begin mon_bad++; $display("FAIL R4 we/oe actual=%0d expected=3", {we_n, oe_n}); end
      end
      if (!m_prev && ras_n) begin
        mon_checks++;
        if (m_ras_run != RASW) begin mon_bad++; $display("FAIL R5 width actual=%0d expected=%0d", m_ras_run, RASW); end
      end
      if (acc_gnt && (!ras_n || !cas_n || ref_busy)) begin
        mon_checks++; mon_bad++;
        $display("FAIL R8 strobes during grant actual=%0d expected=0", {ras_n, cas_n, ref_busy});
      end
      m_cas_run = cas_n ? 0 : m_cas_run + 1;
      m_ras_run = ras_n ? 0 : m_ras_run + 1;
      m_prev = ras_n;
    end
  end

  always @(posedge clk) begin
    wd_cyc++;
    if (wd_cyc > 100000) begin
      $display("FAIL watchdog actual=%0d expected=0", wd_cyc);
      $display("  test done: total=%0d bad=%0d", checks + mon_checks + 1, bad + mon_bad + 1);
      $finish;
    end
  end

  task automatic count_burst(output int falls, output int gmin, output int gmax, output bit gseen);
    bit prev = 1'b1;
    int last = -1;
    int t = 0;
    falls = 0; gmin = 1000000; gmax = 0; gseen = 1'b0;
    while (ready !== 1'b1 && t < 4000) begin
      @(negedge clk);
      t++;
      if (acc_gnt) gseen = 1'b1;
      if (prev && !ras_n) begin
        if (last >= 0) begin
          if (t - last < gmin) gmin = t - last;
          if (t - last > gmax) gmax = t - last;
        end
        last = t;
        falls++;
      end
      prev = ras_n;
    end
  endtask

  task automatic wait_busy_fall();
    bit prev = ref_busy;
    for (int t = 0; t < 4000; t++) begin
      @(negedge clk);
      if (prev && !ref_busy) return;
      prev = ref_busy;
    end
  endtask

  initial begin
    int falls, gmin, gmax, cnt;
    bit gseen, rdy_drop;
    checks = 0; bad = 0; mon_checks = 0; mon_bad = 0; wd_cyc = 0;
    rst_n = 1'b0; acc_req = 1'b1; acc_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1 strobes", {ras_n, cas_n, we_n, oe_n}, 15);
    chk({ready, acc_gnt, ref_busy} == 3'b000, "R1 flags", {ready, acc_gnt, ref_busy}, 0);

    // R2: pause length, request held high throughout
    rst_n = 1'b1;
    cnt = 0; gseen = 1'b0;
    while (cas_n && ras_n && cnt < 1000) begin
      @(negedge clk); cnt++;
      if (acc_gnt) gseen = 1'b1;
    end
    chk(cnt >= PAUSE && cnt <= PAUSE + 2, "R2 pause", cnt, PAUSE);
    chk(!ready, "R3 ready during burst", ready, 0);

    // R3: wake burst
    count_burst(falls, gmin, gmax, bit'(gseen));
    chk(falls == WAKE - 0 - (ras_n ? 0 : 0), "R3 burst count", falls, WAKE);
    chk(gmin == BURST_GAP && gmax == BURST_GAP, "R3 burst spacing", gmax, BURST_GAP);
    chk(!gseen, "R3 no grant before ready", gseen, 0);
    // R7: held request granted next cycle
    @(negedge clk);
    chk(acc_gnt, "R7 grant after ready", acc_gnt, 1);
    acc_req = 1'b0; acc_done = 1'b1;
    @(negedge clk); acc_done = 1'b0;
    chk(!acc_gnt, "R7 grant release", acc_gnt, 0);

    // R6: idle periodic spacing, ready held
    begin
      bit prev = 1'b1;
      int t = 0, f = 0, first = 0;
      rdy_drop = 1'b0;
      while (f < 2 && t < 4000) begin
        @(negedge clk); t++;
        if (!ready) rdy_drop = 1'b1;
        if (prev && !ras_n) begin
          f++;
          if (f == 1) first = t;
          else chk(t - first == IDLE_GAP, "R6 idle spacing", t - first, IDLE_GAP);
        end
        prev = ras_n;
      end
      chk(!rdy_drop, "R6 ready through refresh", rdy_drop, 0);
    end

    // table of access lengths
    for (int i = 0; i < 7; i++) begin
      wait_busy_fall();
      acc_req = 1'b1;
      @(negedge clk);
      chk(acc_gnt, "R7 grant latency", acc_gnt, 1);
      acc_req = 1'b0;
      repeat (TBL[i][0]) @(negedge clk);
      chk(ready == !TBL[i][1], "R9 ready at access end", ready, !TBL[i][1]);
      acc_done = 1'b1;
      @(negedge clk); acc_done = 1'b0;
      chk(!acc_gnt, "R7 grant drop", acc_gnt, 0);
      @(negedge clk);
      chk(ref_busy == TBL[i][2], "R8 deferred refresh start", ref_busy, TBL[i][2]);
      if (TBL[i][1] != 0) begin
        chk(!ready, "R9 ready low in rerun", ready, 0);
        count_burst(falls, gmin, gmax, gseen);
        chk(falls == WAKE, "R9 rerun burst count", falls, WAKE);
        chk(ready, "R9 ready back", ready, 1);
      end
    end

    // R8: request raised as a refresh begins
    begin
      bit prev = ref_busy;
      for (int t = 0; t < 4000; t++) begin
        @(negedge clk);
        if (!prev && ref_busy) break;
        prev = ref_busy;
      end
      acc_req = 1'b1;
      gseen = 1'b0;
      while (ref_busy) begin
        @(negedge clk);
        if (acc_gnt) gseen = 1'b1;
      end
      chk(!gseen && !acc_gnt, "R8 no grant during refresh", gseen, 0);
      @(negedge clk);
      chk(acc_gnt, "R8 grant after refresh", acc_gnt, 1);
    end

    // R1: reset in mid access
    rst_n = 1'b0; acc_req = 1'b0;
    #1;
    chk({ras_n, cas_n, ready, acc_gnt, ref_busy} == 5'b11000, "R1 async reset",
        {ras_n, cas_n, ready, acc_gnt, ref_busy}, 24);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", checks + mon_checks, bad + mon_bad);
    $finish;
  end
endmodule